// File: doc/BRIEF.md
# Capability Dereference Check Unit

This unit sits between a capability-aware pipeline and its MMU. For every load, store or instruction fetch issued through a capability register, it takes the capability's fields (validity tag, sealed flag, permission mask, base, length, offset), the kind of access and its size. It forms the effective virtual address and decides whether the access may go ahead. When the access is refused, it reports a cause code. One request can be accepted each cycle, and the verdict appears from a single register stage on the next cycle.

The pointer itself is never policed: the offset may hold any value, including one that lies far outside the capability's bounds. A fault is raised only when a dereference is attempted, and there are distinct causes for an invalid tag, a sealed capability, a missing permission and a bounds violation. When several violations are present together, only the most important one is reported. The order of importance is tag, then sealed, then permission, then bounds.

Capability-width accesses (loading or storing a whole capability) use a fixed transfer size set by a parameter. Besides the plain load or store right, they also need a capability-specific permission.

Top module: `cap_deref_check`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, rsp_valid, rsp_grant, rsp_fault, rsp_cause and rsp_addr are all zero.
- R2: A request with req_valid high produces rsp_valid high exactly one cycle later. A cycle with req_valid low produces rsp_valid, rsp_grant and rsp_fault all low one cycle later.
- R3: rsp_addr equals cap_base + cap_offset modulo 2^ADDR_W. It is reported for granted and faulted requests alike.
- R4: A clear cap_tag produces a fault with cause 1, whatever the sealed flag, permissions and bounds are.
- R5: A tagged capability with cap_sealed set produces a fault with cause 2, whatever its permissions and bounds are.
- R6: Permission bit 0 allows fetch, bit 1 allows load, bit 2 allows store, bit 3 allows capability load and bit 4 allows capability store. An access whose required bits are not all set faults with cause 3, unless tag or sealed applies first.
- R7: acc_kind encodings are 0 fetch, 1 load, 2 store, 3 capability load and 4 capability store. A capability load needs bits 1 and 3. A capability store needs bits 2 and 4. Both transfer CAP_BYTES bytes and ignore acc_size_lg2.
- R8: The acc_kind values 5, 6 and 7 are reserved. They always fault with cause 3, unless tag or sealed applies first.
- R9: For kinds 0 to 2 the access size is 2^acc_size_lg2 bytes. The access is in bounds only when addr ≥ base and addr + size ≤ base + length, both evaluated without wraparound. Otherwise the access faults with cause 4.
- R10: Any offset value, including one outside the bounds, is accepted without effect until it is used. The verdict depends only on the current request's fields.
- R11: rsp_grant and rsp_fault are never high together. rsp_grant is high exactly when rsp_valid is high and rsp_cause is 0. A fault always carries a non-zero cause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A check request is present this cycle |
| cap_tag | input | 1 | Capability validity tag |
| cap_sealed | input | 1 | Capability is sealed |
| cap_perms | input | PERM_W | Permission mask |
| cap_base | input | ADDR_W | Lower bound |
| cap_length | input | ADDR_W | Size of the accessible region |
| cap_offset | input | ADDR_W | Pointer position relative to base |
| acc_kind | input | 3 | Access kind code |
| acc_size_lg2 | input | SIZE_W | log2 of the access size in bytes (non-capability kinds) |
| rsp_valid | output | 1 | Verdict present |
| rsp_grant | output | 1 | Access allowed |
| rsp_fault | output | 1 | Access refused |
| rsp_cause | output | 3 | 0 none, 1 tag, 2 sealed, 3 permission, 4 bounds |
| rsp_addr | output | ADDR_W | Effective virtual address |

## Verification
The hardest situations to reach are the edges of the bounds check. These include an access whose last byte lands exactly on base + length, a region whose end runs past the top of the address space, and an offset large enough that base + offset wraps below base. Random 64-bit values almost never produce them. The bench therefore builds the unit with an 8-bit address and sweeps every offset for several bases and lengths, including regions that touch the address-space top. Each sweep covers every kind and size, so every boundary byte and every wrapped pointer is visited. Separate sweeps cover all permission masks against all kinds, and all tag and sealed combinations, so that the cause priority is exercised.

// File: rtl/cap_chk_pkg.sv
package cap_chk_pkg;

   localparam logic [2:0] KIND_FETCH     = 3'd0;
   localparam logic [2:0] KIND_LOAD      = 3'd1;
   localparam logic [2:0] KIND_STORE     = 3'd2;
   localparam logic [2:0] KIND_LOAD_CAP  = 3'd3;
   localparam logic [2:0] KIND_STORE_CAP = 3'd4;

   localparam int PB_FETCH     = 0;
   localparam int PB_LOAD      = 1;
   localparam int PB_STORE     = 2;
   localparam int PB_LOAD_CAP  = 3;
   localparam int PB_STORE_CAP = 4;
   localparam int PB_USED      = 5;

   // Fault sources, indexed lowest = most important.
   localparam int NUM_VIOL = 4;
   localparam int VI_TAG    = 0;
   localparam int VI_SEALED = 1;
   localparam int VI_PERM   = 2;
   localparam int VI_BOUNDS = 3;

   localparam logic [2:0] CAUSE_NONE   = 3'd0;
   localparam logic [2:0] CAUSE_TAG    = 3'd1;
   localparam logic [2:0] CAUSE_SEALED = 3'd2;
   localparam logic [2:0] CAUSE_PERM   = 3'd3;
   localparam logic [2:0] CAUSE_BOUNDS = 3'd4;

   typedef struct packed {
      logic       grant;
      logic       fault;
      logic [2:0] cause;
   } verdict_t;

endpackage

// File: rtl/cap_perm_unit.sv
module cap_perm_unit
   import cap_chk_pkg::*;
#(
   parameter int PERM_W = 31
) (
   input  logic [2:0]        kind,
   input  logic [PERM_W-1:0] perms,
   output logic              is_cap,
   output logic              viol
);

   logic [PERM_W-1:0] need;
   logic [PERM_W-1:0] lacking;
   logic              known;

   always_comb begin
      need   = '0;
      known  = 1'b1;
      is_cap = 1'b0;
      case (kind)
         KIND_FETCH: need[PB_FETCH] = 1'b1;
         KIND_LOAD:  need[PB_LOAD]  = 1'b1;
         KIND_STORE: need[PB_STORE] = 1'b1;
         KIND_LOAD_CAP: begin
            need[PB_LOAD]     = 1'b1;
            need[PB_LOAD_CAP] = 1'b1;
            is_cap            = 1'b1;
         end
         KIND_STORE_CAP: begin
            need[PB_STORE]     = 1'b1;
            need[PB_STORE_CAP] = 1'b1;
            is_cap             = 1'b1;
         end
         default: known = 1'b0;
      endcase
   end

   for (genvar i = 0; i < PERM_W; i++) begin : g_lack
      assign lacking[i] = need[i] & ~perms[i];
   end

   assign viol = !known || (|lacking);

   // R8: a reserved kind code can never pass the permission stage
   always_comb begin
      if (kind > KIND_STORE_CAP)
         a_r8_reserved_kind: assert (viol);
   end

endmodule

// File: rtl/cap_bounds_unit.sv
module cap_bounds_unit #(
   parameter int ADDR_W  = 64,
   parameter int BYTES_W = 8
) (
   input  logic [ADDR_W-1:0]  base,
   input  logic [ADDR_W-1:0]  length,
   input  logic [ADDR_W-1:0]  offset,
   input  logic [BYTES_W-1:0] nbytes,
   output logic [ADDR_W-1:0]  addr,
   output logic               viol
);

   localparam int EXT_W = ADDR_W + 1;

   logic [EXT_W-1:0] acc_end;
   logic [EXT_W-1:0] reg_top;
   logic             below;
   logic             above;

   assign addr    = base + offset;
   assign acc_end = {1'b0, addr} + EXT_W'(nbytes);
   assign reg_top = {1'b0, base} + {1'b0, length};
   assign below   = addr < base;
   assign above   = acc_end > reg_top;
   assign viol    = below | above;

endmodule

// File: rtl/cap_fault_prio.sv
module cap_fault_prio
   import cap_chk_pkg::*;
(
   input  logic             req,
   input  logic [NUM_VIOL-1:0] hit,
   output verdict_t         verdict
);

   logic [2:0] cause;

   always_comb begin
      cause = CAUSE_NONE;
      for (int i = NUM_VIOL - 1; i >= 0; i--) begin
         if (hit[i]) cause = 3'(i + 1);
      end
   end

   assign verdict.cause = req ? cause : CAUSE_NONE;
   assign verdict.fault = req && (cause != CAUSE_NONE);
   assign verdict.grant = req && (cause == CAUSE_NONE);

endmodule

// File: rtl/cap_deref_check.sv
module cap_deref_check
   import cap_chk_pkg::*;
#(
   parameter int ADDR_W    = 64,
   parameter int PERM_W    = 31,
   parameter int SIZE_W    = 3,
   parameter int CAP_BYTES = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              cap_tag,
   input  logic              cap_sealed,
   input  logic [PERM_W-1:0] cap_perms,
   input  logic [ADDR_W-1:0] cap_base,
   input  logic [ADDR_W-1:0] cap_length,
   input  logic [ADDR_W-1:0] cap_offset,
   input  logic [2:0]        acc_kind,
   input  logic [SIZE_W-1:0] acc_size_lg2,
   output logic              rsp_valid,
   output logic              rsp_grant,
   output logic              rsp_fault,
   output logic [2:0]        rsp_cause,
   output logic [ADDR_W-1:0] rsp_addr
);

   localparam int BYTES_W = (1 << SIZE_W);

   if (PERM_W < PB_USED) begin : g_bad_perm_w
      $error("PERM_W must hold the five access permission bits");
   end
   if (ADDR_W < 2) begin : g_bad_addr_w
      $error("ADDR_W too small");
   end
   if (SIZE_W < 1 || SIZE_W > 4) begin : g_bad_size_w
      $error("SIZE_W out of range");
   end
   if (CAP_BYTES < 1 || CAP_BYTES >= (1 << BYTES_W)) begin : g_bad_cap_bytes
      $error("CAP_BYTES does not fit the size datapath");
   end

   logic               is_cap;
   logic               perm_viol;
   logic               bnd_viol;
   logic [BYTES_W-1:0] nbytes;
   logic [ADDR_W-1:0]  eff_addr;
   logic [NUM_VIOL-1:0] hit;
   verdict_t           verdict;

   cap_perm_unit #(.PERM_W(PERM_W)) u_perm (
      .kind   (acc_kind),
      .perms  (cap_perms),
      .is_cap (is_cap),
      .viol   (perm_viol)
   );

   assign nbytes = is_cap ? BYTES_W'(CAP_BYTES)
                          : (BYTES_W'(1) << acc_size_lg2);

   cap_bounds_unit #(.ADDR_W(ADDR_W), .BYTES_W(BYTES_W)) u_bounds (
      .base   (cap_base),
      .length (cap_length),
      .offset (cap_offset),
      .nbytes (nbytes),
      .addr   (eff_addr),
      .viol   (bnd_viol)
   );

   always_comb begin
      hit            = '0;
      hit[VI_TAG]    = !cap_tag;
      hit[VI_SEALED] = cap_sealed;
      hit[VI_PERM]   = perm_viol;
      hit[VI_BOUNDS] = bnd_viol;
   end

   cap_fault_prio u_prio (
      .req     (req_valid),
      .hit     (hit),
      .verdict (verdict)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_grant <= 1'b0;
         rsp_fault <= 1'b0;
         rsp_cause <= CAUSE_NONE;
         rsp_addr  <= '0;
      end else begin
         rsp_valid <= req_valid;
         rsp_grant <= verdict.grant;
         rsp_fault <= verdict.fault;
         rsp_cause <= verdict.cause;
         if (req_valid) rsp_addr <= eff_addr;
      end
   end

   a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);
   a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> (!rsp_valid && !rsp_grant && !rsp_fault));
   a_r4_tag_first: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !cap_tag) |=> (rsp_fault && rsp_cause == CAUSE_TAG));
   a_r5_sealed_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && cap_tag && cap_sealed) |=> (rsp_fault && rsp_cause == CAUSE_SEALED));
   a_r3_addr_formed: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> (rsp_addr == $past(cap_base) + $past(cap_offset)));
   a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(rsp_grant && rsp_fault));
   a_r11_fault_cause: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_fault |-> (rsp_cause != CAUSE_NONE));
   a_r11_grant_clean: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_grant |-> (rsp_valid && rsp_cause == CAUSE_NONE));

endmodule

// File: tb/cap_deref_check_bench.sv
module cap_deref_check_bench;

   localparam int AW = 8;
   localparam int PW = 5;
   localparam int SW = 2;
   localparam int CB = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          cap_tag = 1'b0;
   logic          cap_sealed = 1'b0;
   logic [PW-1:0] cap_perms = '0;
   logic [AW-1:0] cap_base = '0;
   logic [AW-1:0] cap_length = '0;
   logic [AW-1:0] cap_offset = '0;
   logic [2:0]    acc_kind = '0;
   logic [SW-1:0] acc_size_lg2 = '0;
   logic          rsp_valid, rsp_grant, rsp_fault;
   logic [2:0]    rsp_cause;
   logic [AW-1:0] rsp_addr;

   int n_cmp = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   cap_deref_check #(.ADDR_W(AW), .PERM_W(PW), .SIZE_W(SW), .CAP_BYTES(CB)) u_cap_deref_check (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
      .cap_tag(cap_tag), .cap_sealed(cap_sealed), .cap_perms(cap_perms),
      .cap_base(cap_base), .cap_length(cap_length), .cap_offset(cap_offset),
      .acc_kind(acc_kind), .acc_size_lg2(acc_size_lg2),
      .rsp_valid(rsp_valid), .rsp_grant(rsp_grant), .rsp_fault(rsp_fault),
      .rsp_cause(rsp_cause), .rsp_addr(rsp_addr)
   );

   task automatic compare(input string req, input logic [13:0] got, input logic [13:0] exp);
      n_cmp++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got valid/grant/fault/cause/addr=%b_%b_%b_%0d_%0d expected %b_%b_%b_%0d_%0d",
                  req, got[13], got[12], got[11], got[10:8], got[7:0],
                  exp[13], exp[12], exp[11], exp[10:8], exp[7:0]);
      end
   endtask

   // Driven at a falling edge; verdict checked at the next falling edge.
   task automatic one(input string req, input int tg, input int sl, input int pm,
                      input int b, input int l, input int o, input int k, input int lg);
      int addr, nb, need, cause;
      logic bad_perm, bad_bnd;
      cap_tag = 1'(tg); cap_sealed = 1'(sl); cap_perms = PW'(pm);
      cap_base = AW'(b); cap_length = AW'(l); cap_offset = AW'(o);
      acc_kind = 3'(k); acc_size_lg2 = SW'(lg); req_valid = 1'b1;
      addr = (b + o) % 256;
      nb   = (k == 3 || k == 4) ? CB : (1 << lg);
      case (k)
         0: need = 1;
         1: need = 2;
         2: need = 4;
         3: need = 2 | 8;
         4: need = 4 | 16;
         default: need = -1;
      endcase
      bad_perm = (need < 0) || ((need & pm) != need);
      bad_bnd  = (addr < b) || (addr + nb > b + l);
      if (tg == 0) cause = 1;
      else if (sl != 0) cause = 2;
      else if (bad_perm) cause = 3;
      else if (bad_bnd) cause = 4;
      else cause = 0;
      @(negedge clk);
      compare(req, {rsp_valid, rsp_grant, rsp_fault, rsp_cause, rsp_addr},
              {1'b1, cause == 0, cause != 0, 3'(cause), 8'(addr)});
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      int bases[3] = '{0, 200, 250};
      int lens[3]  = '{0, 7, 60};
      repeat (3) @(negedge clk);
      // R1: reset state
      compare("R1", {rsp_valid, rsp_grant, rsp_fault, rsp_cause, rsp_addr}, 14'd0);
      rst_n = 1'b1;
      @(negedge clk);
      compare("R1", {rsp_valid, rsp_grant, rsp_fault, rsp_cause, rsp_addr}, 14'd0);

      // R9 R3 R10 R7: sweep of every offset across bounds, kinds and sizes
      foreach (bases[bi]) foreach (lens[li])
         for (int o = 0; o < 256; o++)
            for (int k = 0; k < 8; k++)
               for (int lg = 0; lg < 4; lg++)
                  one("R9_R3_R10", 1, 0, 31, bases[bi], lens[li], o, k, lg);

      // R6 R7 R8: every permission mask against every kind, in bounds
      for (int pm = 0; pm < 32; pm++)
         for (int k = 0; k < 8; k++)
            one("R6_R7_R8", 1, 0, pm, 16, 64, 8, k, 0);

      // R4 R5: tag and sealed priority over permission and bounds faults
      for (int tg = 0; tg < 2; tg++)
         for (int sl = 0; sl < 2; sl++)
            for (int pm = 0; pm < 32; pm += 31)
               for (int o = 0; o < 200; o += 100)
                  one("R4_R5", tg, sl, pm, 10, 20, o, 1, 1);

      // R2: idle cycle after a fault gives a quiet response
      one("R2", 0, 0, 0, 0, 0, 0, 0, 0);
      req_valid = 1'b0;
      @(negedge clk);
      n_cmp++;
      if (rsp_valid !== 1'b0 || rsp_grant !== 1'b0 || rsp_fault !== 1'b0) begin
         n_bad++;
         $display("FAIL R2: got valid/grant/fault=%b%b%b expected 000", rsp_valid, rsp_grant, rsp_fault);
      end
      // R11 R2: grant right after an idle cycle
      one("R11_R2", 1, 0, 31, 100, 50, 49, 1, 0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule